// File: doc/BRIEF.md
# Burst Read Acknowledge Ignore-State Controller

This block runs the master side of a read transfer and decides on which clock edges the transfer acknowledge may be believed. A start strobe opens either a single read or a line read of four long-word beats. On each beat a down-counter is loaded with a programmable ignore count. While that counter is above zero, the acknowledge input has no effect. When the counter is empty, the acknowledge is sampled on every edge until it is seen, and at that point the beat's data is captured.

Two 4-bit ignore counts are captured while reset is held. The primary count governs the first beat of a transfer and the secondary count governs every later beat. A status output goes high for the one clock period that ends on the first edge at which a beat's acknowledge is sampled. This lets a system that keeps the acknowledge asserted all the time see exactly where each beat is taken. When the mode enable is low at the start of a transfer, the counts are bypassed and every edge samples the acknowledge.

Top module: `bag_ctrl`

## Requirements
- R1: `prim_cnt_i` and `sec_cnt_i` are captured on every rising edge while `rst_n` is low. Changing them after reset has no effect on any later transfer.
- R2: The start edge is the rising edge at which `start_i` is accepted. With the mode on, the first beat ignores the acknowledge on the P edges that follow the start edge, where P is the primary count. Edge P+1 after the start edge is the first sampling edge.
- R3: With the mode on, each beat after the first ignores the acknowledge for S edges after the edge that accepted the previous beat, where S is the secondary count. The next edge is that beat's first sampling edge.
- R4: On an edge where the ignore counter is non-zero, an asserted `ack_i` captures nothing. `cap_o` stays low in the following cycle.
- R5: With the mode on, `samp_o` is high for exactly the clock period that ends at a beat's first sampling edge, and it is low at all other times.
- R6: If `ack_i` is low on a sampling edge, wait states are added. The beat is accepted on the first later edge with `ack_i` high, and `samp_o` stays low during those wait states.
- R7: An accepted beat raises `cap_o` for one cycle after the accepting edge. In that cycle `beat_o` holds the beat number: 0 to 3 for a line read (`line_i`=1 at start), and 0 only for a single read.
- R8: `done_o` pulses for one cycle together with the `cap_o` of the last beat of the transfer.
- R9: If `mode_en_i` is low on the start edge, no edge of that transfer is ignored and `samp_o` stays low.
- R10: `start_i` asserted while a transfer is in progress is ignored and does not open a further transfer.
- R11: After reset, `cap_o`, `samp_o`, `done_o` and `beat_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Active-low reset; ignore counts are captured while it is low |
| start_i | input | 1 | Transfer start strobe, taken only when idle |
| line_i | input | 1 | 1 = four-beat line read, 0 = single read; taken with start |
| ack_i | input | 1 | Transfer acknowledge from the slave |
| mode_en_i | input | 1 | Ignore-state mode enable, taken with start |
| prim_cnt_i | input | 4 | Ignore count for the first beat |
| sec_cnt_i | input | 4 | Ignore count for later beats |
| cap_o | output | 1 | Data-capture strobe, one cycle per accepted beat |
| samp_o | output | 1 | Status: the period ending at the first sampling edge of a beat |
| beat_o | output | 2 | Index of the beat being captured |
| done_o | output | 1 | One-cycle pulse with the last capture of a transfer |

## Verification
A wrong count reload or decrement moves a beat's acceptance edge. This shows up as `cap_o` rising one or more cycles early or late against the reference model, within the same beat. A stale sampling flag shows up as a `samp_o` pulse that is extra, missing or repeated during wait states, one period before the affected edge. A beat counter that goes wrong is caught at the next capture through `beat_o`, or by `done_o` arriving on the wrong beat.

// File: rtl/bag_pkg.sv
package bag_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } bag_state_e;

    localparam int BAG_CNT_W_DEF = 4;
    localparam int BAG_BEATS_DEF = 4;
endpackage

// File: rtl/bag_cfg_latch.sv
module bag_cfg_latch #(
    parameter int CNT_W = 4,
    parameter int SETS  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SETS-1:0][CNT_W-1:0]  cnt_in_i,
    output logic [SETS-1:0][CNT_W-1:0]  cnt_o
);
    for (genvar g = 0; g < SETS; g++) begin : g_set
        logic [CNT_W-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (!rst_n) begin
                val_d = cnt_in_i[g];
            end
        end

        always_ff @(posedge clk) begin
            val_q <= val_d;
        end

        assign cnt_o[g] = val_q;
    end
endmodule

// File: rtl/bag_ign_counter.sv
module bag_ign_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/bag_ctrl.sv
module bag_ctrl
    import bag_pkg::*;
#(
    parameter int CNT_W      = BAG_CNT_W_DEF,
    parameter int LINE_BEATS = BAG_BEATS_DEF,
    localparam int BEAT_W    = (LINE_BEATS > 2) ? $clog2(LINE_BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              line_i,
    input  logic              ack_i,
    input  logic              mode_en_i,
    input  logic [CNT_W-1:0]  prim_cnt_i,
    input  logic [CNT_W-1:0]  sec_cnt_i,
    output logic              cap_o,
    output logic              samp_o,
    output logic [BEAT_W-1:0] beat_o,
    output logic              done_o
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(LINE_BEATS - 1);

    typedef struct packed {
        bag_state_e        state;
        logic              mode;
        logic              line;
        logic [BEAT_W-1:0] beat;
        logic              fresh;
        logic              cap;
        logic [BEAT_W-1:0] cap_beat;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [1:0][CNT_W-1:0] cfg_cnt;
    logic                  ld;
    logic [CNT_W-1:0]      ld_val;
    logic [CNT_W-1:0]      cnt;
    logic                  zero;
    logic                  busy;
    logic                  mode_w;
    logic                  line_w;

    bag_cfg_latch #(.CNT_W(CNT_W), .SETS(2)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_in_i ({sec_cnt_i, prim_cnt_i}),
        .cnt_o    (cfg_cnt)
    );

    bag_ign_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ld),
        .load_val_i (ld_val),
        .run_i      (busy),
        .cnt_o      (cnt),
        .zero_o     (zero)
    );

    assign busy   = (seq_q.state == ST_BUSY);
    assign mode_w = seq_q.mode;
    assign line_w = seq_q.line;

    always_comb begin
        seq_d      = seq_q;
        seq_d.cap  = 1'b0;
        seq_d.done = 1'b0;
        ld         = 1'b0;
        ld_val     = '0;
        if (!busy) begin
            if (start_i) begin
                seq_d.state = ST_BUSY;
                seq_d.mode  = mode_en_i;
                seq_d.line  = line_i;
                seq_d.beat  = '0;
                seq_d.fresh = 1'b1;
                ld          = 1'b1;
                ld_val      = mode_en_i ? cfg_cnt[0] : '0;
            end
        end else if (zero) begin
            seq_d.fresh = 1'b0;
            if (ack_i) begin
                seq_d.cap      = 1'b1;
                seq_d.cap_beat = seq_q.beat;
                if (!seq_q.line || (seq_q.beat == LAST_BEAT)) begin
                    seq_d.state = ST_IDLE;
                    seq_d.done  = 1'b1;
                end else begin
                    seq_d.beat  = seq_q.beat + 1'b1;
                    seq_d.fresh = 1'b1;
                    ld          = 1'b1;
                    ld_val      = seq_q.mode ? cfg_cnt[1] : '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, mode: 1'b0, line: 1'b0, beat: '0,
                       fresh: 1'b0, cap: 1'b0, cap_beat: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign samp_o = busy && seq_q.mode && zero && seq_q.fresh;
    assign cap_o  = seq_q.cap;
    assign beat_o = seq_q.cap_beat;
    assign done_o = seq_q.done;
endmodule

// File: rtl/bag_ctrl_chk.sv
module bag_ctrl_chk #(
    parameter int CNT_W  = 4,
    parameter int BEAT_W = 2,
    parameter int LINE_BEATS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              ack_i,
    input logic              cap_o,
    input logic              samp_o,
    input logic              done_o,
    input logic [BEAT_W-1:0] beat_o,
    input logic              busy,
    input logic              mode_w,
    input logic              line_w,
    input logic              zero,
    input logic [CNT_W-1:0]  cnt
);
    localparam logic [BEAT_W-1:0] LAST_B = BEAT_W'(LINE_BEATS - 1);

    // R4: counting edge never yields a capture
    a_r4_no_cap_while_counting: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cnt != '0)) |=> !cap_o);

    // R6: a sampling edge without acknowledge drops the status in the wait state
    a_r6_samp_drops_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_o && !ack_i) |=> !samp_o);

    // R8: completion coincides with a capture
    a_r8_done_with_cap: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> cap_o);

    // R7: the closing capture carries the final beat number
    a_r7_last_beat_index: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (beat_o == (line_w ? LAST_B : '0)));

    // R9: bypassed transfers never hold a non-zero ignore count
    a_r9_bypass_counts_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mode_w) |-> zero);

    // R10: a start during a transfer does not end or restart it
    a_r10_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_i && !(zero && ack_i)) |=> busy);
endmodule

bind bag_ctrl bag_ctrl_chk #(.CNT_W(CNT_W), .BEAT_W(BEAT_W), .LINE_BEATS(LINE_BEATS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .ack_i   (ack_i),
    .cap_o   (cap_o),
    .samp_o  (samp_o),
    .done_o  (done_o),
    .beat_o  (beat_o),
    .busy    (busy),
    .mode_w  (mode_w),
    .line_w  (line_w),
    .zero    (zero),
    .cnt     (cnt)
);

// File: tb/test_bag_ctrl.sv
module test_bag_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       line_i = 1'b0;
    logic       ack_i = 1'b0;
    logic       mode_en_i = 1'b0;
    logic [3:0] prim_cnt_i = 4'd0;
    logic [3:0] sec_cnt_i = 4'd0;
    logic       cap_o, samp_o, done_o;
    logic [1:0] beat_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    bag_ctrl i_bag_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .line_i(line_i),
        .ack_i(ack_i), .mode_en_i(mode_en_i), .prim_cnt_i(prim_cnt_i),
        .sec_cnt_i(sec_cnt_i), .cap_o(cap_o), .samp_o(samp_o),
        .beat_o(beat_o), .done_o(done_o)
    );

    // behavioural reference model
    int m_prim, m_sec, m_cnt, m_beat, m_capbeat;
    bit m_act, m_mode, m_line, m_fresh, m_cap, m_done;
    int done_seen = 0;
    bit samp_seen = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_prim = prim_cnt_i; m_sec = sec_cnt_i;
            m_act = 0; m_cap = 0; m_done = 0; m_capbeat = 0; m_cnt = 0;
            m_fresh = 0; m_mode = 0; m_line = 0; m_beat = 0;
        end else begin
            m_cap = 0; m_done = 0;
            if (!m_act) begin
                if (start_i) begin
                    m_act = 1; m_mode = mode_en_i; m_line = line_i; m_beat = 0;
                    m_fresh = 1; m_cnt = mode_en_i ? m_prim : 0;
                end
            end else if (m_cnt > 0) begin
                m_cnt = m_cnt - 1;
            end else begin
                m_fresh = 0;
                if (ack_i) begin
                    m_cap = 1; m_capbeat = m_beat;
                    if (!m_line || m_beat == 3) begin
                        m_act = 0; m_done = 1;
                    end else begin
                        m_beat++; m_fresh = 1; m_cnt = m_mode ? m_sec : 0;
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cyc %0d)", req, act, exp, cyc);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit exp_samp;
            exp_samp = m_act && m_mode && (m_cnt == 0) && m_fresh;
            chk(cap_o == m_cap, "R4 cap_o", cap_o, m_cap);
            chk(samp_o == exp_samp, "R5 samp_o", samp_o, exp_samp);
            chk(done_o == m_done, "R8 done_o", done_o, m_done);
            if (m_cap) chk(beat_o == m_capbeat[1:0], "R7 beat_o", beat_o, m_capbeat);
            if (done_o) done_seen++;
            if (samp_o) samp_seen = 1;
        end
    end

    task automatic do_reset(input int p, input int s);
        @(negedge clk);
        rst_n = 0; prim_cnt_i = 4'(p); sec_cnt_i = 4'(s);
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    // line/single transfer with ack held; check capture timing
    task automatic run_timed(input bit line, input bit mode, input int first, input int gap,
                             input string req);
        int s0, last, n;
        @(negedge clk);
        start_i = 1; line_i = line; mode_en_i = mode; ack_i = 1;
        @(negedge clk);
        start_i = 0;
        s0 = cyc; last = s0; n = 0;
        for (int k = 0; k < 200; k++) begin
            if (cap_o) begin
                chk((cyc - last) == ((n == 0) ? first : gap), req, cyc - last,
                    (n == 0) ? first : gap);
                last = cyc; n++;
                if (done_o) break;
            end
            @(negedge clk);
        end
        chk(n == (line ? 4 : 1), "R7 beat count", n, line ? 4 : 1);
        ack_i = 0;
        @(negedge clk);
    endtask

    initial begin
        int d0;
        // counts 2/3 captured during reset, then the inputs change
        do_reset(2, 3);
        prim_cnt_i = 4'd7; sec_cnt_i = 4'd7;
        @(negedge clk);
        chk(cap_o == 0 && samp_o == 0 && done_o == 0 && beat_o == 0, "R11 reset outputs",
            {cap_o, samp_o, done_o, beat_o}, 0);
        run_timed(1, 1, 3, 4, "R1 R2 R3 capture spacing");
        run_timed(0, 1, 3, 0, "R2 single read");

        // counts 1/1, acknowledge held continuously
        do_reset(1, 1);
        run_timed(1, 1, 2, 2, "R3 skip one edge per beat");

        // zero counts: sample on the first eligible edge
        do_reset(0, 0);
        run_timed(1, 1, 1, 1, "R2 zero count");

        // bypass mode with non-zero counts
        do_reset(5, 5);
        samp_seen = 0;
        run_timed(1, 0, 1, 1, "R9 bypass timing");
        chk(samp_seen == 0, "R9 samp_o stays low", samp_seen, 0);

        // wait states with a slow, patterned acknowledge
        do_reset(1, 2);
        for (int t = 0; t < 6; t++) begin
            @(negedge clk);
            start_i = 1; line_i = (t != 2); mode_en_i = (t != 4);
            for (int k = 0; k < 60; k++) begin
                @(negedge clk);
                start_i = (k == 3);   // R10: stray start mid-transfer
                ack_i = ((k * 7 + t) % 5) == 0;
                if (done_o) break;
            end
            ack_i = 0; start_i = 0;
            repeat (2) @(negedge clk);
        end

        // R10: one start, a second start while busy -> one completion only
        d0 = done_seen;
        @(negedge clk);
        start_i = 1; line_i = 1; mode_en_i = 1; ack_i = 1;
        @(negedge clk);
        @(negedge clk);
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        repeat (20) @(negedge clk);
        ack_i = 0;
        chk((done_seen - d0) == 1, "R10 start ignored while busy", done_seen - d0, 1);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule